// File: doc/BRIEF.md
# Atomic Snoop Bus Arbiter with Memory Responder

This block is the shared broadcast bus of a small multicore cluster. Each core node pulses a request line to place a read-for-sharing (GETS) or read-for-ownership (GETM) query. The arbiter puts one query at a time on the bus and keeps the bus locked until the single DATA response for that query has been seen. Requests that arrive while the bus is locked wait in an arrival-ordered queue. Requests that arrive in the same cycle are ordered by node index, lowest first.

A built-in memory responder answers every query after a fixed, parameterised latency. If any cache drives DATA onto the bus first, the memory reply for that query is cancelled. The block then marks the response as a cache-to-cache transfer. This includes the case where the requesting node supplies the data itself. Coherence state and data payloads are handled outside the block. The bus only orders queries and tells the caches who answered.

Top module: `coh_bus_fabric`

## Requirements
- R1: After reset, bus_busy, q_valid and d_valid are all 0.
- R2: A request pulse from node n in cycle t, with an idle bus and an empty queue, makes q_valid high for exactly one cycle in cycle t+2. In that cycle q_src=n, and q_getm and q_addr hold the values that node presented with its pulse (q_getm 0 = GETS, 1 = GETM).
- R3: From the q_valid cycle until the matching d_valid cycle, no other query is placed on the bus. Each query receives exactly one d_valid cycle.
- R4: Requests waiting for the bus are granted in order of arrival.
- R5: Among requests that arrive in the same cycle, the lower node index is granted first.
- R6: With no cache response, memory DATA appears exactly LAT cycles after the q_valid cycle, with d_from_mem=1, c2c=0 and d_src=0.
- R7: A cache_dv pulse while the bus is locked produces d_valid in that same cycle, with d_from_mem=0, c2c=1 and d_src equal to cache_src. No memory DATA follows for that query.
- R8: Data supplied by the requesting node itself also counts as a cache-to-cache transfer (c2c=1).
- R9: A cache_dv pulse while the bus is idle is ignored: d_valid stays 0.
- R10: When a request is waiting, the next query appears in the cycle right after d_valid.
- R11: If a cache responds in the same cycle the memory timer expires, the cache response wins and there is a single d_valid with d_from_mem=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_pulse | input | N | One-cycle request pulse per node |
| req_getm | input | N | Query type per node with its pulse (1 = GETM) |
| req_addr | input | N*AW | Query address per node, node n at bits [n*AW +: AW] |
| cache_dv | input | 1 | A cache drives DATA this cycle |
| cache_src | input | IW | Id of the cache driving DATA |
| bus_busy | output | 1 | Bus locked by an outstanding query |
| q_valid | output | 1 | Query broadcast pulse |
| q_getm | output | 1 | Broadcast query type |
| q_addr | output | AW | Broadcast query address |
| q_src | output | IW | Requesting node |
| d_valid | output | 1 | DATA response this cycle |
| d_from_mem | output | 1 | DATA came from memory |
| d_src | output | IW | Supplying cache id (0 for memory) |
| c2c | output | 1 | Response is a cache-to-cache transfer |

## Verification
On every cycle, the assertions check the following properties. No new query may appear while the bus is locked without a response. No DATA may appear while the bus is idle. A cache response always wins over memory. A waiting request must follow a response at once. The arrival queue must never overflow. The memory timer must never fire twice in a row. Only the bench scenarios can show the properties that depend on history. These are the arrival and index ordering of grants, the exact memory latency, the identity of the supplier, and the query fields carried from each node.

// File: rtl/coh_bus_pkg.sv
package coh_bus_pkg;
   typedef enum logic {
      QRY_GETS = 1'b0,
      QRY_GETM = 1'b1
   } qry_kind_e;

   function automatic int id_bits(input int nodes);
      return (nodes <= 2) ? 1 : $clog2(nodes);
   endfunction
endpackage

// File: rtl/arrival_fifo.sv
module arrival_fifo #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  push_vec,
   input  logic          pop,
   output logic [IW-1:0] head_id,
   output logic          nonempty
);
   localparam int CW = $clog2(N + 1);

   logic [IW-1:0] slot_q [N];
   logic [IW-1:0] slot_d [N];
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      for (int i = 0; i < N; i++) slot_d[i] = slot_q[i];
      cnt_d = cnt_q;
      if (pop && cnt_q != '0) begin
         for (int i = 0; i < N - 1; i++) slot_d[i] = slot_q[i + 1];
         cnt_d = cnt_q - 1'b1;
      end
      for (int n = 0; n < N; n++) begin
         if (push_vec[n] && int'(cnt_d) < N) begin
            slot_d[cnt_d[IW-1:0]] = IW'(n);
            cnt_d = cnt_d + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < N; i++) slot_q[i] <= '0;
      end else begin
         cnt_q <= cnt_d;
         for (int i = 0; i < N; i++) slot_q[i] <= slot_d[i];
      end
   end

   assign head_id  = slot_q[0];
   assign nonempty = (cnt_q != '0);

   // R4: one entry per node at most, so the queue never exceeds N
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_q) + $countones(push_vec) - ((pop && nonempty) ? 1 : 0)) <= N);
endmodule

// File: rtl/mem_responder.sv
module mem_responder #(
   parameter int LAT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   output logic fire
);
   localparam int TW = $clog2(LAT + 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (start)                         cnt_q <= '0;
      else if (active && cnt_q != TW'(LAT))   cnt_q <= cnt_q + 1'b1;
   end

   assign fire = active && (cnt_q == TW'(LAT));

   // R6: memory answers at most once per query window
   a_r6_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !start |=> !fire);
endmodule

// File: rtl/coh_bus_fabric.sv
module coh_bus_fabric #(
   parameter int N   = 4,
   parameter int AW  = 16,
   parameter int LAT = 100,
   parameter int IW  = coh_bus_pkg::id_bits(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req_pulse,
   input  logic [N-1:0]    req_getm,
   input  logic [N*AW-1:0] req_addr,
   input  logic            cache_dv,
   input  logic [IW-1:0]   cache_src,
   output logic            bus_busy,
   output logic            q_valid,
   output logic            q_getm,
   output logic [AW-1:0]   q_addr,
   output logic [IW-1:0]   q_src,
   output logic            d_valid,
   output logic            d_from_mem,
   output logic [IW-1:0]   d_src,
   output logic            c2c
);
   import coh_bus_pkg::*;

   if (N < 2 || N > 64) begin : g_bad_n
      $error("coh_bus_fabric: N out of range");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("coh_bus_fabric: LAT must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("coh_bus_fabric: AW must be positive");
   end

   // per-node capture of query fields at request time
   qry_kind_e     kind_q [N];
   logic [AW-1:0] addr_q [N];

   for (genvar n = 0; n < N; n++) begin : g_node
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            kind_q[n] <= QRY_GETS;
            addr_q[n] <= '0;
         end else if (req_pulse[n]) begin
            kind_q[n] <= qry_kind_e'(req_getm[n]);
            addr_q[n] <= req_addr[n*AW +: AW];
         end
      end
   end

   logic [IW-1:0] head_id;
   logic          waiting;
   logic          grant;
   logic          busy_q;
   logic          mem_fire;

   assign grant = (!busy_q || d_valid) && waiting;

   arrival_fifo #(.N(N), .IW(IW)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_vec (req_pulse),
      .pop      (grant),
      .head_id  (head_id),
      .nonempty (waiting)
   );

   mem_responder #(.LAT(LAT)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (grant),
      .active (busy_q),
      .fire   (mem_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         q_valid <= 1'b0;
         q_getm  <= 1'b0;
         q_addr  <= '0;
         q_src   <= '0;
      end else begin
         q_valid <= grant;
         if (grant) begin
            busy_q <= 1'b1;
            q_src  <= head_id;
            q_getm <= (kind_q[head_id] == QRY_GETM);
            q_addr <= addr_q[head_id];
         end else if (d_valid) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign bus_busy   = busy_q;
   assign d_valid    = busy_q && (cache_dv || mem_fire);
   assign d_from_mem = d_valid && !cache_dv;
   assign d_src      = (busy_q && cache_dv) ? cache_src : '0;
   assign c2c        = busy_q && cache_dv;

   // R3: a locked bus without a response admits no new query
   a_r3_hold_lock: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !d_valid |=> !q_valid);
   // R2: a broadcast query always comes with a locked bus
   a_r2_query_locks: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> bus_busy);
   // R9: no response while idle
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !d_valid);
   // R11: a cache response overrides memory
   a_r11_cache_wins: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && cache_dv |-> d_valid && c2c && !d_from_mem);
   // R10: a waiting request is broadcast right after the response
   a_r10_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid && waiting |=> q_valid);
endmodule

// File: tb/coh_bus_fabric_bench.sv
module coh_bus_fabric_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 4;
   localparam int AW  = 16;
   localparam int LAT = 100;
   localparam int IW  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_pulse = '0;
   logic [N-1:0]    req_getm = '0;
   logic [N*AW-1:0] req_addr = '0;
   logic            cache_dv = 1'b0;
   logic [IW-1:0]   cache_src = '0;
   logic            bus_busy, q_valid, q_getm, d_valid, d_from_mem, c2c;
   logic [AW-1:0]   q_addr;
   logic [IW-1:0]   q_src, d_src;

   coh_bus_fabric #(.N(N), .AW(AW), .LAT(LAT)) u_coh_bus_fabric (
      .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .req_getm(req_getm),
      .req_addr(req_addr), .cache_dv(cache_dv), .cache_src(cache_src),
      .bus_busy(bus_busy), .q_valid(q_valid), .q_getm(q_getm), .q_addr(q_addr),
      .q_src(q_src), .d_valid(d_valid), .d_from_mem(d_from_mem), .d_src(d_src),
      .c2c(c2c)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int src; int typ; int addr; int at; int gap; int lat; int mem; int dsrc;
   } item_t;

   item_t exp_q[$];
   item_t cur;
   int    checks = 0, failures = 0;
   bit    outstanding = 0;
   int    qcyc = 0, last_d = -10;
   bit    finished = 0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // driver: issue a request and push its expectation
   task automatic issue(input int n, input int typ, input int addr, input int at,
                        input int gap, input int lat, input int mem, input int dsrc);
      item_t it;
      it = '{src:n, typ:typ, addr:addr, at:at, gap:gap, lat:lat, mem:mem, dsrc:dsrc};
      exp_q.push_back(it);
      req_pulse[n] = 1'b1;
      req_getm[n]  = typ[0];
      req_addr[n*AW +: AW] = AW'(addr);
   endtask

   task automatic end_pulse();
      @(negedge clk);
      req_pulse = '0;
   endtask

   task automatic wait_query();
      do @(negedge clk); while (!q_valid);
   endtask

   task automatic cache_supply(input int id);
      cache_dv  = 1'b1;
      cache_src = IW'(id);
      @(negedge clk);
      cache_dv  = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || outstanding) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: pop and compare as the design produces results
   always @(negedge clk) begin
      #1;
      if (rst_n && q_valid) begin
         check(exp_q.size() != 0, "R3 unexpected query", 1, 0);
         check(!outstanding, "R3 query while locked", 1, 0);
         if (exp_q.size() != 0) begin
            cur = exp_q.pop_front();
            check(int'(q_src) == cur.src, "R4/R5 q_src order", int'(q_src), cur.src);
            check(int'(q_getm) == cur.typ, "R2 q_getm", int'(q_getm), cur.typ);
            check(int'(q_addr) == cur.addr, "R2 q_addr", int'(q_addr), cur.addr);
            if (cur.at >= 0) check(cyc == cur.at, "R2 grant cycle", cyc, cur.at);
            if (cur.gap >= 0) check(cyc - last_d == cur.gap, "R10 back-to-back", cyc - last_d, cur.gap);
            outstanding = 1;
            qcyc = cyc;
         end
      end
      if (rst_n && d_valid) begin
         check(outstanding, "R3/R9 data without query", 0, 1);
         if (outstanding) begin
            check(cyc - qcyc == cur.lat, "R6/R7 response latency", cyc - qcyc, cur.lat);
            check(int'(d_from_mem) == cur.mem, "R6/R7 d_from_mem", int'(d_from_mem), cur.mem);
            check(int'(c2c) == 1 - cur.mem, "R7/R8 c2c", int'(c2c), 1 - cur.mem);
            check(int'(d_src) == cur.dsrc, "R7 d_src", int'(d_src), cur.dsrc);
         end
         outstanding = 0;
         last_d = cyc;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!bus_busy && !q_valid && !d_valid, "R1 reset state",
            int'({bus_busy, q_valid, d_valid}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!bus_busy, "R1 idle after reset", int'(bus_busy), 0);

      // R9: cache data while idle is ignored
      cache_supply(1);
      check(!d_valid && !bus_busy, "R9 idle cache data", int'(d_valid), 0);

      // R2, R6: single GETM answered by memory
      issue(2, 1, 16'h1234, cyc + 2, -1, LAT, 1, 0);
      end_pulse();
      drain();

      // R5 then R4: nodes 1 and 3 together, node 0 a cycle later; R10 gaps
      issue(1, 0, 16'h0100, cyc + 2, -1, LAT, 1, 0);
      issue(3, 1, 16'h0300, -1, 1, LAT, 1, 0);
      end_pulse();
      issue(0, 0, 16'h0001, -1, 1, LAT, 1, 0);
      end_pulse();
      drain();

      // R7: another cache supplies five cycles into the window
      issue(0, 1, 16'hBEEF, -1, -1, 5, 0, 2);
      end_pulse();
      wait_query();
      repeat (5) @(negedge clk);
      cache_supply(2);
      drain();

      // R8: requester supplies itself in the query cycle
      issue(3, 0, 16'h0033, -1, -1, 0, 0, 3);
      end_pulse();
      wait_query();
      cache_supply(3);
      drain();

      // R11: cache response coincides with memory timer expiry
      issue(1, 1, 16'h7777, -1, -1, LAT, 0, 1);
      end_pulse();
      wait_query();
      repeat (LAT) @(negedge clk);
      cache_supply(1);
      repeat (LAT + 5) @(negedge clk);
      check(!outstanding && exp_q.size() == 0, "R7/R11 no extra memory data",
            exp_q.size(), 0);
      drain();

      finished = 1;
   end

   initial begin
      int t;
      t = 0;
      while (!finished && t < 20000) begin
         @(posedge clk);
         t++;
      end
      if (!finished) check(0, "watchdog expired", t, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule